// File: doc/BRIEF.md
# Table-Encoded Clock Divider with Gate

This block divides an incoming clock by a ratio chosen from a small set of non-power-of-two values. A 4-bit selector code in a 16-bit control register picks the ratio through a fixed decode. A disable bit in the same register stops the outputs. The block drives two outputs. The first is a one-cycle enable pulse once per divide period, for logic that stays on the parent clock. The second is a square-wave output that is high for the first half of each period.

The control register is written field by field. A selector strobe and a gate strobe each update only their own field from the shared write data, so a write to one field never disturbs the other. A selector write with a code that has no ratio is rejected and raises an error flag. A new ratio, and a change of the gate, take effect only at the end of the period in progress. This keeps every output period whole.

Top module: `tdiv_gate`

## Requirements
- R1: After reset the register reads 16'h0101 (gate set, selector code 1), and clkEn, clkOut and selErr are low. The outputs stay low until the gate is cleared.
- R2: The register holds the selector at bits 3:0 and the gate at bit 8. All other bits read as zero, whatever data is written.
- R3: Selector codes decode to divide ratios as 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36 and 11→48. While running, clkEn pulses high for exactly one cycle every N cycles, where N is the ratio.
- R4: A selector write with code 0, 9 or 12 to 15 leaves the selector field and the active ratio unchanged.
- R5: A selector write with an invalid code sets selErr from the next cycle on. A later selector write with a valid code clears it.
- R6: wrSel changes only bits 3:0 and wrGate changes only bit 8. Both strobes in the same cycle update both fields.
- R7: The active ratio changes only at the end of a divide period. The period in progress when a new code is written completes at the old length.
- R8: clkOut is high for the first ceil(N/2) cycles of each N-cycle period, which gives a 50% duty for even ratios. clkEn is high only in a cycle where clkOut is low.
- R9: Writing 1 to the gate lets the current period finish, with its clkEn pulse, and then holds both outputs low. Writing 0 restarts division from the start of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrSel | input | 1 | Write strobe for the selector field |
| wrGate | input | 1 | Write strobe for the gate field |
| wrData | input | 16 | Write data, with the selector at bits 3:0 and the gate at bit 8 |
| rdData | output | 16 | Current register contents |
| selErr | output | 1 | Last selector write carried an invalid code |
| clkEn | output | 1 | One-cycle pulse at the last cycle of each period |
| clkOut | output | 1 | Divided square-wave output |

## Verification
The assertions assume that wrSel and wrGate are single-cycle strobes, sampled on the rising edge, and that wrData is valid whenever either strobe is high. They also assume that reset is held for at least one edge before any write. The bench drives every write on a falling edge and releases it one cycle later, so each write lands on exactly one rising edge. It changes ratios only after observing a pulse, which keeps every period measurement aligned to a whole period.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

  localparam int SEL_W   = 4;
  localparam int RATIO_W = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic periodEnd;  // current period finishes at this edge
    logic loadRatio;  // take pending ratio into the counter
    logic runNext;    // next period runs (gate clear)
  } tdivStrobe_t;

  // selector code to divide ratio; zero marks an invalid code
  function automatic logic [RATIO_W-1:0] ratioOf(input logic [SEL_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      4'd1:    r = RATIO_W'(3);
      4'd2:    r = RATIO_W'(4);
      4'd3:    r = RATIO_W'(6);
      4'd4:    r = RATIO_W'(8);
      4'd5:    r = RATIO_W'(12);
      4'd6:    r = RATIO_W'(16);
      4'd7:    r = RATIO_W'(18);
      4'd8:    r = RATIO_W'(24);
      4'd10:   r = RATIO_W'(36);
      4'd11:   r = RATIO_W'(48);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic codeOk(input logic [SEL_W-1:0] code);
    return ratioOf(code) != '0;
  endfunction

endpackage

// File: rtl/tdiv_ctrl.sv
module tdiv_ctrl
  import tdiv_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int GATE_POS = 8,
  parameter logic [SEL_W-1:0] RESET_SEL = 4'd1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrSel,
  input  logic               wrGate,
  input  logic [REG_W-1:0]   wrData,
  input  logic               running,
  input  logic               lastCycle,
  output logic [REG_W-1:0]   regView,
  output logic               selErr,
  output logic [RATIO_W-1:0] pendRatio,
  output tdivStrobe_t        strobe
);

  logic [SEL_W-1:0] selQ;
  logic             gateQ;
  logic             errQ;
  logic [SEL_W-1:0] newSel;
  logic             newOk;

  assign newSel = wrData[SEL_W-1:0];
  assign newOk  = codeOk(newSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= RESET_SEL;
      gateQ <= 1'b1;
      errQ  <= 1'b0;
    end else begin
      if (wrSel) begin
        if (newOk) selQ <= newSel;
        errQ <= ~newOk;
      end
      if (wrGate) gateQ <= wrData[GATE_POS];
    end
  end

  always_comb begin
    regView                  = '0;
    regView[SEL_W-1:0]       = selQ;
    regView[GATE_POS]        = gateQ;
  end

  assign selErr    = errQ;
  assign pendRatio = ratioOf(selQ);

  always_comb begin
    strobe.periodEnd = ~running | lastCycle;
    strobe.loadRatio = ~running | lastCycle;
    strobe.runNext   = ~gateQ;
  end

endmodule

// File: rtl/tdiv_datapath.sv
module tdiv_datapath
  import tdiv_pkg::*;
#(
  parameter logic [RATIO_W-1:0] RESET_RATIO = RATIO_W'(3)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tdivStrobe_t        strobe,
  input  logic [RATIO_W-1:0] pendRatio,
  output logic               clkEn,
  output logic               clkOut,
  output logic               running,
  output logic [RATIO_W-1:0] curRatio
);

  logic [RATIO_W-1:0] cntQ, cntN;
  logic [RATIO_W-1:0] ratioQ, ratioN;
  logic               runQ, runN;
  logic               enQ, outQ;
  logic [RATIO_W-1:0] highLen;

  always_comb begin
    if (strobe.periodEnd) begin
      runN   = strobe.runNext;
      cntN   = '0;
      ratioN = strobe.loadRatio ? pendRatio : ratioQ;
    end else begin
      runN   = runQ;
      cntN   = cntQ + RATIO_W'(1);
      ratioN = ratioQ;
    end
    // ceil(N/2) high cycles
    highLen = ratioN - (ratioN >> 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      ratioQ <= RESET_RATIO;
      runQ   <= 1'b0;
      enQ    <= 1'b0;
      outQ   <= 1'b0;
    end else begin
      cntQ   <= cntN;
      ratioQ <= ratioN;
      runQ   <= runN;
      enQ    <= runN & (cntN == ratioN - RATIO_W'(1));
      outQ   <= runN & (cntN < highLen);
    end
  end

  assign clkEn    = enQ;
  assign clkOut   = outQ;
  assign running  = runQ;
  assign curRatio = ratioQ;

endmodule

// File: rtl/tdiv_gate.sv
module tdiv_gate
  import tdiv_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int GATE_POS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrSel,
  input  logic             wrGate,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             selErr,
  output logic             clkEn,
  output logic             clkOut
);

  localparam logic [SEL_W-1:0]   RESET_SEL   = 4'd1;
  localparam logic [RATIO_W-1:0] RESET_RATIO = ratioOf(RESET_SEL);

  tdivStrobe_t        strobe;
  logic [RATIO_W-1:0] pendRatio;
  logic [RATIO_W-1:0] curRatio;
  logic               running;

  tdiv_ctrl #(
    .REG_W(REG_W), .GATE_POS(GATE_POS), .RESET_SEL(RESET_SEL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrSel(wrSel), .wrGate(wrGate), .wrData(wrData),
    .running(running), .lastCycle(clkEn), .regView(rdData), .selErr(selErr),
    .pendRatio(pendRatio), .strobe(strobe)
  );

  tdiv_datapath #(
    .RESET_RATIO(RESET_RATIO)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pendRatio(pendRatio),
    .clkEn(clkEn), .clkOut(clkOut), .running(running), .curRatio(curRatio)
  );

endmodule

// File: rtl/tdiv_checker.sv
module tdiv_checker
  import tdiv_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int GATE_POS = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrSel,
  input logic               wrGate,
  input logic [REG_W-1:0]   wrData,
  input logic [REG_W-1:0]   rdData,
  input logic               selErr,
  input logic               clkEn,
  input logic               clkOut,
  input logic               running,
  input logic [RATIO_W-1:0] curRatio
);

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    codeOk(rdData[SEL_W-1:0])); // R4

  AST_BAD_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrSel && !codeOk(wrData[SEL_W-1:0])) |=> $stable(rdData[SEL_W-1:0])); // R4

  AST_BAD_SEL_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrSel && !codeOk(wrData[SEL_W-1:0])) |=> selErr); // R5

  AST_GATE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (wrSel && !wrGate) |=> $stable(rdData[GATE_POS])); // R6

  AST_SEL_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (wrGate && !wrSel) |=> $stable(rdData[SEL_W-1:0])); // R6

  AST_RATIO_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curRatio) |-> $past(!running || clkEn)); // R7

  AST_PULSE_LOW_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> !clkOut); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!clkEn && !clkOut)); // R9

endmodule

bind tdiv_gate tdiv_checker #(.REG_W(REG_W), .GATE_POS(GATE_POS)) u_chk (
  .clk(clk), .rstN(rstN), .wrSel(wrSel), .wrGate(wrGate), .wrData(wrData),
  .rdData(rdData), .selErr(selErr), .clkEn(clkEn), .clkOut(clkOut),
  .running(running), .curRatio(curRatio)
);

// File: tb/tdiv_gate_bench.sv
`timescale 1ns/1ps
module tdiv_gate_bench;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrSel = 1'b0;
  logic        wrGate = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        selErr, clkEn, clkOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdiv_gate u_tdiv_gate (
    .clk(clk), .rstN(rstN), .wrSel(wrSel), .wrGate(wrGate), .wrData(wrData),
    .rdData(rdData), .selErr(selErr), .clkEn(clkEn), .clkOut(clkOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input bit s, input bit g, input logic [15:0] d);
    @(negedge clk);
    wrSel = s; wrGate = g; wrData = d;
    @(negedge clk);
    wrSel = 0; wrGate = 0; wrData = '0;
  endtask

  // wait at negedges until clkEn is seen; returns cycles waited or -1
  task automatic waitPulse(output int waited);
    waited = -1;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (clkEn) begin waited = i; return; end
    end
  endtask

  // called right after a pulse: length of next period and clkOut high count
  task automatic measure(output int gap, output int highs);
    gap = 0; highs = 0;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      gap++;
      if (clkOut) highs++;
      if (clkEn) return;
    end
    gap = -1;
  endtask

  function automatic int expRatio(input int code);
    case (code)
      1: return 3;   2: return 4;   3: return 6;   4: return 8;
      5: return 12;  6: return 16;  7: return 18;  8: return 24;
      10: return 36; 11: return 48;
      default: return 0;
    endcase
  endfunction

  task automatic testReset();
    int pulses = 0, highs = 0;
    check("R1", "register after reset", rdData, 16'h0101);
    check("R1", "selErr after reset", selErr, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      pulses += clkEn; highs += clkOut;
    end
    check("R1", "pulses while gated", pulses, 0);
    check("R1", "clkOut highs while gated", highs, 0);
  endtask

  task automatic testAllRatios();
    int w, gap, highs;
    writeReg(1, 1, 16'h0001); // ungate, code 1
    for (int code = 1; code <= 11; code++) begin
      if (expRatio(code) == 0) continue;
      writeReg(1, 0, 16'(code));
      waitPulse(w);              // may still be old period
      measure(gap, highs);       // first whole period at new ratio
      check("R3", $sformatf("period code %0d", code), gap, expRatio(code));
      check("R8", $sformatf("high count code %0d", code), highs,
            (expRatio(code) + 1) / 2);
    end
  endtask

  task automatic testInvalid();
    int w, gap, highs;
    int bad[7] = '{0, 9, 12, 13, 14, 15, 0};
    writeReg(1, 0, 16'h0002); // ratio 4
    writeReg(1, 0, 16'h0003); // valid clears error
    check("R5", "selErr after valid write", selErr, 0);
    for (int k = 0; k < 6; k++) begin
      writeReg(1, 0, 16'(bad[k]));
      check("R4", $sformatf("selector after code %0d", bad[k]), rdData[3:0], 3);
      check("R5", $sformatf("selErr after code %0d", bad[k]), selErr, 1);
    end
    waitPulse(w);
    measure(gap, highs);
    check("R4", "ratio kept after invalid codes", gap, 6);
    writeReg(1, 0, 16'h0004);
    check("R5", "selErr cleared by valid code", selErr, 0);
  endtask

  task automatic testFields();
    writeReg(1, 0, 16'hFEF5); // code 5, gate bit 0, junk elsewhere
    check("R2", "register ignores other bits", rdData, 16'h0005);
    writeReg(0, 1, 16'h000B); // gate write with code bits 11
    check("R6", "gate write keeps selector", rdData[3:0], 5);
    check("R6", "gate write keeps gate clear", rdData[8], 0);
    writeReg(1, 0, 16'h0107); // selector write with gate bit set
    check("R6", "selector write keeps gate", rdData[8], 0);
    check("R6", "selector write updates code", rdData[3:0], 7);
    writeReg(1, 1, 16'h0102);
    check("R6", "joint write", rdData, 16'h0102);
    writeReg(0, 1, 16'h0000);
  endtask

  task automatic testChangeAtEnd();
    int w, gap, highs;
    writeReg(1, 0, 16'h0006); // ratio 16
    waitPulse(w); measure(gap, highs);
    // now just after a pulse; write new code one cycle into the period
    @(negedge clk);
    wrSel = 1; wrData = 16'h0001;
    @(negedge clk);
    wrSel = 0; wrData = '0;
    gap = 2;
    for (int i = 0; i < 100 && !clkEn; i++) begin @(negedge clk); gap++; end
    check("R7", "period in progress keeps old ratio", gap, 16);
    measure(gap, highs);
    check("R7", "next period uses new ratio", gap, 3);
  endtask

  task automatic testGate();
    int w, gap, highs, pulses = 0, outs = 0;
    writeReg(1, 0, 16'h0004); // ratio 8
    waitPulse(w); measure(gap, highs);
    @(negedge clk);
    wrGate = 1; wrData = 16'h0100;
    @(negedge clk);
    wrGate = 0; wrData = '0;
    waitPulse(w);
    check("R9", "final pulse after gate write", (w > 0) ? 1 : 0, 1);
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      pulses += clkEn; outs += clkOut;
    end
    check("R9", "pulses after gating", pulses, 0);
    check("R9", "clkOut highs after gating", outs, 0);
    writeReg(0, 1, 16'h0000);
    waitPulse(w);
    check("R9", "first pulse after ungate", w, 8);
    measure(gap, highs);
    check("R9", "period after ungate", gap, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testAllRatios();
    testInvalid();
    testFields();
    testChangeAtEnd();
    testGate();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule